// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block answers byte-wide configuration accesses for a simple single-function I/O device. Each access carries a function number, an 8-bit register offset, a write strobe and write data. The block holds the identity bytes, a command register, one I/O base address register and the interrupt line and pin. It drives the decoded I/O base and an enable qualifier to the I/O register block that sits behind the window.

The block implements only the writable fields: the two low command bits, the upper base address bits and the interrupt line. Every other implemented offset is a constant or reads as zero. The base address register always reports a 32-byte I/O window, so enumeration software can size it by writing all ones and reading back. An access completes in one cycle. Read data is registered and appears on the cycle after the request.

Top module: `cfg_space_resp`

## Requirements
- R1: For function 0, offsets 0x00, 0x01, 0x02 and 0x03 read 0x1A, 0x07, 0x0B and 0xAB (vendor ID 0x071A, device ID 0xAB0B, little-endian bytes).
- R2: Offsets 0x2C to 0x2F return the same four identity bytes as offsets 0x00 to 0x03, in the same byte order.
- R3: The command register at offset 0x04 resets to 0x03. A write keeps only bits 1:0. A read returns those two bits with bits 7:2 at zero. Offset 0x05 reads 0x00.
- R4: A write to offset 0x10 stores only bits 7:5. A read of 0x10 returns the stored bits 7:5 with bit 0 at 1 and bits 4:1 at 0, so after reset it reads 0x01.
- R5: Offsets 0x11, 0x12 and 0x13 store the written byte and read it back unchanged. io_base_o equals {byte 0x13, byte 0x12, byte 0x11, stored bits 7:5 of 0x10, 5'b0}.
- R6: The interrupt line at 0x3C resets to 0x00 and is read/write. The interrupt pin at 0x3D always reads 0x04, and writes to it are ignored.
- R7: io_en_o is 1 exactly when command bit 0 is 1 and io_base_o[15:5] is nonzero. It follows any command or base address write in the cycle after the write edge. Base bits 31:16 alone do not enable the window.
- R8: Offsets 0x06 to 0x0B and every unimplemented offset read 0x00. Writes to them change no register and no output.
- R9: An access with a function number other than 0 reads 0x00 and writes nothing.
- R10: cfg_rdata_o resets to 0x00 and changes only on the clock edge that samples a read request. It holds its value through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration access strobe, one cycle per access |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_func_i | input | 3 | Function number |
| cfg_addr_i | input | 8 | Register offset |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Registered read data |
| io_base_o | output | 32 | Decoded I/O window base |
| io_en_o | output | 1 | I/O window enable qualifier |

## Verification
The bench writes all ones to the base register and expects 0xE1 back. A design that stored the low bits, or dropped the forced bit 0, would return 0xFF or 0xE0 and report the wrong window size. It sets base bits only above bit 15 and expects the window to stay disabled. A decoder that tested all 32 bits would enable it. It clears and sets command bit 0 around a valid base to catch an enable that is not re-evaluated after each write. It also writes to read-only offsets, to the pin and to a nonzero function, then reads back to confirm nothing moved. Finally it idles and writes after a read to expose read data that changes outside a read.

// File: rtl/cfg_resp_pkg.sv
package cfg_resp_pkg;
  localparam int CMD_W = 2;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_BAR0  = 8'h10;
  localparam logic [7:0] OFS_ILINE = 8'h3C;
  localparam logic [7:0] OFS_IPIN  = 8'h3D;
  localparam logic [5:0] DW_ID     = 6'h00;  // dword holding vendor/device
  localparam logic [5:0] DW_SUBID  = 6'h0B;  // dword 0x2C, mirrors identity
endpackage

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_resp_pkg::*;
#(
  parameter int              IO_WIN_BITS = 5,
  parameter logic [CMD_W-1:0] CMD_RST    = 2'b11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [31:0]      bar_o,
  output logic [7:0]       line_o
);
  localparam logic [31:0] BAR_MASK = 32'hFFFF_FFFF << IO_WIN_BITS;

  logic [CMD_W-1:0] cmd_q;
  logic [31:0]      bar_q;
  logic [7:0]       line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_RST;
      line_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_CMD)   cmd_q  <= wdata_i[CMD_W-1:0];
      if (addr_i == OFS_ILINE) line_q <= wdata_i;
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_bar_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bar_q[8*b +: 8] <= '0;
      end else if (wr_en_i && addr_i == OFS_BAR0 + 8'(b)) begin
        bar_q[8*b +: 8] <= wdata_i & BAR_MASK[8*b +: 8];
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign bar_o  = bar_q;
  assign line_o = line_q;

  AST_LINE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_ILINE) |=> line_o == $past(wdata_i)); // R6
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_resp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h071A,
  parameter logic [15:0] DEVICE_ID   = 16'hAB0B,
  parameter logic [7:0]  INT_PIN     = 8'h04,
  parameter int          IO_WIN_BITS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic             func_ok_i,
  input  logic [7:0]       addr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [31:0]      bar_i,
  input  logic [7:0]       line_i,
  output logic [7:0]       rdata_o
);
  localparam logic [31:0] ID_WORD = {DEVICE_ID, VENDOR_ID};

  logic [7:0] mux_d;
  logic [7:0] rdata_q;

  always_comb begin
    mux_d = '0;
    if (addr_i[7:2] == DW_ID || addr_i[7:2] == DW_SUBID) begin
      mux_d = ID_WORD[8*addr_i[1:0] +: 8];
    end else begin
      case (addr_i)
        OFS_CMD:          mux_d = {{(8-CMD_W){1'b0}}, cmd_i};
        OFS_BAR0:         mux_d = bar_i[7:0] | 8'h01;  // I/O space indicator
        OFS_BAR0 + 8'd1:  mux_d = bar_i[15:8];
        OFS_BAR0 + 8'd2:  mux_d = bar_i[23:16];
        OFS_BAR0 + 8'd3:  mux_d = bar_i[31:24];
        OFS_ILINE:        mux_d = line_i;
        OFS_IPIN:         mux_d = INT_PIN;
        default:          mux_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (rd_req_i) rdata_q <= func_ok_i ? mux_d : '0;
  end

  assign rdata_o = rdata_q;

  AST_CMD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && func_ok_i && addr_i == OFS_CMD) |=> rdata_o[7:CMD_W] == '0); // R3
  AST_BAR_IO_IND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && func_ok_i && addr_i == OFS_BAR0)
    |=> (rdata_o[0] && rdata_o[IO_WIN_BITS-1:1] == '0)); // R4
  AST_PIN_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && func_ok_i && addr_i == OFS_IPIN) |=> rdata_o == INT_PIN); // R6
  AST_OTHER_FUNC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !func_ok_i) |=> rdata_o == 8'h00); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/cfg_io_decode.sv
module cfg_io_decode #(
  parameter int IO_WIN_BITS = 5,
  parameter int IO_DEC_BITS = 16
) (
  input  logic        io_cmd_i,
  input  logic [31:0] bar_i,
  output logic [31:0] io_base_o,
  output logic        io_en_o
);
  // only the decoded I/O address range counts toward a valid base
  assign io_base_o = {bar_i[31:IO_WIN_BITS], {IO_WIN_BITS{1'b0}}};
  assign io_en_o   = io_cmd_i && (|bar_i[IO_DEC_BITS-1:IO_WIN_BITS]);
endmodule

// File: rtl/cfg_space_resp.sv
module cfg_space_resp
  import cfg_resp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h071A,
  parameter logic [15:0] DEVICE_ID   = 16'hAB0B,
  parameter logic [7:0]  INT_PIN     = 8'h04,
  parameter int          IO_WIN_BITS = 5,
  parameter int          IO_DEC_BITS = 16,
  parameter int          FUNC_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_req_i,
  input  logic              cfg_we_i,
  input  logic [FUNC_W-1:0] cfg_func_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic [31:0]       io_base_o,
  output logic              io_en_o
);
  logic             func_ok;
  logic             wr_en;
  logic             rd_req;
  logic [CMD_W-1:0] cmd;
  logic [31:0]      bar;
  logic [7:0]       line;

  assign func_ok = (cfg_func_i == '0);
  assign wr_en   = cfg_req_i && cfg_we_i && func_ok;
  assign rd_req  = cfg_req_i && !cfg_we_i;

  cfg_reg_file #(
    .IO_WIN_BITS (IO_WIN_BITS),
    .CMD_RST     (2'b11)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cmd_o   (cmd),
    .bar_o   (bar),
    .line_o  (line)
  );

  cfg_rd_port #(
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .INT_PIN     (INT_PIN),
    .IO_WIN_BITS (IO_WIN_BITS)
  ) i_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_req_i  (rd_req),
    .func_ok_i (func_ok),
    .addr_i    (cfg_addr_i),
    .cmd_i     (cmd),
    .bar_i     (bar),
    .line_i    (line),
    .rdata_o   (cfg_rdata_o)
  );

  cfg_io_decode #(
    .IO_WIN_BITS (IO_WIN_BITS),
    .IO_DEC_BITS (IO_DEC_BITS)
  ) i_dec (
    .io_cmd_i  (cmd[0]),
    .bar_i     (bar),
    .io_base_o (io_base_o),
    .io_en_o   (io_en_o)
  );

  AST_EN_CMD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && cfg_addr_i == OFS_CMD && !cfg_wdata_i[0]) |=> !io_en_o); // R7
  AST_BAR_TOP_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && cfg_addr_i == OFS_BAR0 + 8'd3) |=> io_base_o[31:24] == $past(cfg_wdata_i)); // R5
  AST_OTHER_FUNC_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_we_i && !func_ok) |=> $stable(io_base_o) && $stable(io_en_o)); // R9
endmodule

// File: tb/test_cfg_space_resp.sv
module test_cfg_space_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  func = '0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] io_base;
  logic        io_en;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_space_resp i_cfg_space_resp (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we),
    .cfg_func_i(func), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .io_base_o(io_base), .io_en_o(io_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; func = f; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] f, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; func = f; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 rdata reset", 32'(rdata), 32'h00);
    chk("R7 io_en reset", 32'(io_en), 32'h0);
    chk("R5 io_base reset", io_base, 32'h0);
    cfg_rd(0, 8'h04, d); chk("R3 cmd reset", 32'(d), 32'h03);
    cfg_rd(0, 8'h10, d); chk("R4 bar0 reset", 32'(d), 32'h01);
    cfg_rd(0, 8'h3C, d); chk("R6 line reset", 32'(d), 32'h00);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    logic [7:0] exp [4] = '{8'h1A, 8'h07, 8'h0B, 8'hAB};
    for (int i = 0; i < 4; i++) begin
      cfg_rd(0, 8'(i), d);          chk("R1 identity", 32'(d), 32'(exp[i]));
      cfg_rd(0, 8'h2C + 8'(i), d);  chk("R2 subsystem mirror", 32'(d), 32'(exp[i]));
    end
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    cfg_wr(0, 8'h04, 8'hFF); cfg_rd(0, 8'h04, d); chk("R3 cmd FF", 32'(d), 32'h03);
    cfg_wr(0, 8'h04, 8'hFE); cfg_rd(0, 8'h04, d); chk("R3 cmd FE", 32'(d), 32'h02);
    cfg_wr(0, 8'h05, 8'hFF); cfg_rd(0, 8'h05, d); chk("R3 cmd hi", 32'(d), 32'h00);
  endtask

  task automatic t_bar();
    logic [7:0] d;
    cfg_wr(0, 8'h10, 8'hFF); cfg_rd(0, 8'h10, d); chk("R4 bar0 size", 32'(d), 32'hE1);
    cfg_wr(0, 8'h11, 8'h34);
    cfg_wr(0, 8'h12, 8'h56);
    cfg_wr(0, 8'h13, 8'h78);
    cfg_rd(0, 8'h11, d); chk("R5 bar1", 32'(d), 32'h34);
    cfg_rd(0, 8'h12, d); chk("R5 bar2", 32'(d), 32'h56);
    cfg_rd(0, 8'h13, d); chk("R5 bar3", 32'(d), 32'h78);
    chk("R5 io_base", io_base, 32'h785634E0);
    cfg_wr(0, 8'h10, 8'h5A); cfg_rd(0, 8'h10, d); chk("R4 bar0 5A", 32'(d), 32'h41);
  endtask

  task automatic t_window();
    cfg_wr(0, 8'h04, 8'h01);
    cfg_wr(0, 8'h10, 8'h00);
    cfg_wr(0, 8'h11, 8'h00);
    cfg_wr(0, 8'h12, 8'h55);
    cfg_wr(0, 8'h13, 8'hAA);
    chk("R7 high bits only", 32'(io_en), 32'h0);
    cfg_wr(0, 8'h11, 8'h03);
    chk("R7 enable", 32'(io_en), 32'h1);
    chk("R5 io_base win", io_base, 32'hAA550300);
    cfg_wr(0, 8'h04, 8'h00);
    chk("R7 cmd off", 32'(io_en), 32'h0);
    cfg_wr(0, 8'h04, 8'h01);
    chk("R7 cmd on", 32'(io_en), 32'h1);
    cfg_wr(0, 8'h11, 8'h00);
    chk("R7 base zero", 32'(io_en), 32'h0);
    cfg_wr(0, 8'h10, 8'h20);
    chk("R7 bit5 base", 32'(io_en), 32'h1);
  endtask

  task automatic t_intr();
    logic [7:0] d;
    cfg_wr(0, 8'h3C, 8'h0B); cfg_rd(0, 8'h3C, d); chk("R6 line", 32'(d), 32'h0B);
    cfg_wr(0, 8'h3D, 8'h00); cfg_rd(0, 8'h3D, d); chk("R6 pin", 32'(d), 32'h04);
  endtask

  task automatic t_ro();
    logic [7:0] d;
    logic [7:0] ofs [7] = '{8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h40};
    for (int i = 0; i < 7; i++) begin
      cfg_wr(0, ofs[i], 8'hFF);
      cfg_rd(0, ofs[i], d); chk("R8 ro/unimpl", 32'(d), 32'h00);
    end
    cfg_wr(0, 8'hFF, 8'hFF);
    chk("R8 base unchanged", io_base, 32'hAA550020);
    chk("R8 en unchanged", 32'(io_en), 32'h1);
    cfg_rd(0, 8'h3C, d); chk("R8 line unchanged", 32'(d), 32'h0B);
  endtask

  task automatic t_func();
    logic [7:0] d;
    cfg_wr(1, 8'h3C, 8'h77);
    cfg_wr(3, 8'h04, 8'h00);
    cfg_wr(7, 8'h13, 8'h00);
    cfg_rd(0, 8'h3C, d); chk("R9 line kept", 32'(d), 32'h0B);
    chk("R9 en kept", 32'(io_en), 32'h1);
    chk("R9 base kept", io_base, 32'hAA550020);
    cfg_rd(1, 8'h00, d); chk("R9 read func1", 32'(d), 32'h00);
    cfg_rd(5, 8'h3D, d); chk("R9 read func5", 32'(d), 32'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    cfg_rd(0, 8'h03, d); chk("R10 read", 32'(d), 32'hAB);
    repeat (3) @(negedge clk);
    chk("R10 idle hold", 32'(rdata), 32'hAB);
    cfg_wr(0, 8'h3C, 8'h22);
    chk("R10 write hold", 32'(rdata), 32'hAB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_cmd();
    t_bar();
    t_window();
    t_intr();
    t_ro();
    t_func();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule